// File: doc/BRIEF.md
# Parallel GPIO Port with Peripheral Output Override

This block is one parallel I/O port of configurable width, placed between a simple register bus and a row of pad cells. Every pin has a direction bit and an output latch bit. A third read view returns the pin levels. Software writes the direction and latch registers through one write strobe per register. A third strobe, for the port address, also writes the latch. Read data comes from a combinational multiplexer that the read select steers.

Pad input values pass through a two-stage synchronizer before they reach the pin view. For each pin the block also drives an output enable and output data toward the pad. On override-capable pins, an attached peripheral that raises its active-drive flag takes ownership of both of these signals. The pin can still be read through the port while the peripheral owns it. Pins whose only sharing is with an input-only function have no override path. An implementation mask removes bits that a given instance does not have. Those bits hold no state, drive nothing and read as zero.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset every implemented direction bit reads 1, meaning input. The latch reads 0, pad_oe is all 0 and pad_out is all 0.
- R2: A direction bit of 1 makes its pin an input. A bit of 0 makes it an output. While no peripheral owns the pin, pad_oe for that bit equals the inverse of the direction bit from the clock edge that follows a wr_dir strobe.
- R3: With rd_sel = 1, rdata returns the stored latch contents and not the pin levels.
- R4: A wr_port strobe writes wdata into the output latch, exactly as a wr_lat strobe does.
- R5: With rd_sel = 2, rdata returns pad_in sampled through two flops. A change on pad_in appears after the second rising edge and not after the first.
- R6: On an override-capable pin whose per_drive bit is 1, pad_oe follows per_oe and pad_out follows per_out. The pin still reads through rd_sel = 2.
- R7: On a pin whose per_drive bit is 0, pad_oe is the inverted direction bit and pad_out is the latch bit.
- R8: On bits that are 0 in IMPL_MASK, the latch and direction are held at 0, all read views return 0, and pad_oe and pad_out are 0.
- R9: On bits that are 0 in OVR_MASK (input-only sharing), per_drive, per_oe and per_out have no effect on pad_oe or pad_out.
- R10: rdata follows rd_sel in the same cycle. The encoding is 0 direction, 1 latch, 2 pins, 3 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Write strobe for the direction register |
| wr_lat | input | 1 | Write strobe for the output latch |
| wr_port | input | 1 | Write strobe for the port address; writes the latch |
| wdata | input | WIDTH | Write data |
| rd_sel | input | 2 | Read view select: 0 dir, 1 latch, 2 pins, 3 zero |
| rdata | output | WIDTH | Read data for the selected view |
| pad_in | input | WIDTH | Levels sampled from the pads |
| pad_oe | output | WIDTH | Output enable toward the pads |
| pad_out | output | WIDTH | Output data toward the pads |
| per_drive | input | WIDTH | Peripheral active-drive flag per pin |
| per_oe | input | WIDTH | Peripheral output enable per pin |
| per_out | input | WIDTH | Peripheral output data per pin |

## Verification
The bench builds an 8-bit instance. Bit 7 is unimplemented, and bits 4 to 6 have no override path. Every 8-bit value is swept through the direction register, through the latch using the two write strobes in turn, and through pad_in. The pad_in sweep checks the pin view after one edge and again after two, which separates a two-stage synchronizer from a one-stage one. During the latch sweep pad_in is held at the complement, so a latch read that leaks the pins shows up. Every per_drive value is then tried with its own per_oe and per_out patterns over a fixed direction and latch. This separates owned pins from port pins and separates override-capable bits from input-only bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } gpio_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_lat,
    input  logic             wr_port,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_dir) begin
            st_d.dir = wdata & IMPL_MASK;
        end
        // port address and latch address both land in the latch
        if (wr_lat || wr_port) begin
            st_d.lat = wdata & IMPL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= IMPL_MASK;
            st_q.lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q = st_q.dir;
    assign lat_q = st_q.lat;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1,
    parameter logic [WIDTH-1:0] OVR_MASK  = '1
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] per_drive,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (!IMPL_MASK[b]) begin : g_absent
            assign pad_oe[b]  = 1'b0;
            assign pad_out[b] = 1'b0;
        end else if (OVR_MASK[b]) begin : g_shared
            always_comb begin
                if (per_drive[b]) begin
                    pad_oe[b]  = per_oe[b];
                    pad_out[b] = per_out[b];
                end else begin
                    pad_oe[b]  = ~dir_q[b];
                    pad_out[b] = lat_q[b];
                end
            end
        end else begin : g_dedicated
            assign pad_oe[b]  = ~dir_q[b];
            assign pad_out[b] = lat_q[b];
        end
    end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1,
    parameter logic [WIDTH-1:0] OVR_MASK  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_lat,
    input  logic             wr_port,
    input  logic [WIDTH-1:0] wdata,
    input  logic [1:0]       rd_sel,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    input  logic [WIDTH-1:0] per_drive,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_out
);
    import gpio_pkg::*;

    logic [WIDTH-1:0] dir_q, lat_q, pin_q;

    gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_dir), .wr_lat(wr_lat), .wr_port(wr_port),
        .wdata(wdata), .dir_q(dir_q), .lat_q(lat_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pin_q)
    );

    gpio_pad_mux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK), .OVR_MASK(OVR_MASK)) u_mux (
        .dir_q(dir_q), .lat_q(lat_q),
        .per_drive(per_drive), .per_oe(per_oe), .per_out(per_out),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always_comb begin
        case (gpio_sel_e'(rd_sel))
            SEL_DIR: rdata = dir_q;
            SEL_LAT: rdata = lat_q;
            SEL_PIN: rdata = pin_q & IMPL_MASK;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1,
    parameter logic [WIDTH-1:0] OVR_MASK  = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_dir,
    input logic             wr_lat,
    input logic             wr_port,
    input logic [WIDTH-1:0] wdata,
    input logic [1:0]       rd_sel,
    input logic [WIDTH-1:0] rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] per_drive,
    input logic [WIDTH-1:0] per_oe
);
    logic [WIDTH-1:0] own;
    assign own = per_drive & OVR_MASK & IMPL_MASK;

    // R8: absent bits never drive and never read back
    a_r8_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | rdata) & ~IMPL_MASK) == '0);

    // R4: either latch strobe lands wdata in the latch view
    a_r4_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lat || wr_port) |=> (rd_sel != 2'd1 || rdata == ($past(wdata) & IMPL_MASK)));

    // R6: an owning peripheral sets the pad enable
    a_r6_owner_oe: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ per_oe) & own) == '0);

    // R2: direction write shows on port-owned pad enables
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> ((pad_oe & ~own & IMPL_MASK) == (~$past(wdata) & ~own & IMPL_MASK)));

    // R9: input-only bits keep their pad data unless the latch is written
    a_r9_no_override: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lat || wr_port) |=> $stable(pad_out & ~OVR_MASK & IMPL_MASK));
endmodule

bind gpio_port_mux gpio_port_mux_chk #(
    .WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK), .OVR_MASK(OVR_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_lat(wr_lat),
    .wr_port(wr_port), .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .per_drive(per_drive), .per_oe(per_oe)
);

// File: tb/gpio_port_mux_bench.sv
module gpio_port_mux_bench;
    localparam int         W    = 8;
    localparam logic [7:0] IMPL = 8'h7F;
    localparam logic [7:0] OVR  = 8'h0F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_dir = 1'b0, wr_lat = 1'b0, wr_port = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rdata, pad_oe, pad_out;
    logic [W-1:0] pad_in = '0, per_drive = '0, per_oe = '0, per_out = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port_mux #(.WIDTH(W), .IMPL_MASK(IMPL), .OVR_MASK(OVR)) u_gpio_port_mux (
        .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_lat(wr_lat),
        .wr_port(wr_port), .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .per_drive(per_drive), .per_oe(per_oe), .per_out(per_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_view(input logic [1:0] sel, output logic [W-1:0] v);
        rd_sel = sel;
        #1 v = rdata;
    endtask

    task automatic write_reg(input int which, input logic [W-1:0] v);
        wdata = v;
        wr_dir  = (which == 0);
        wr_lat  = (which == 1);
        wr_port = (which == 2);
        step();
        wr_dir = 1'b0; wr_lat = 1'b0; wr_port = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] prev;
        logic [W-1:0] own, po, pv, dir_c, lat_c;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_view(2'd0, v); chk("R1 dir reset", v, IMPL);
        read_view(2'd1, v); chk("R1 latch reset", v, 8'h00);
        chk("R1 pad_oe reset", pad_oe, 8'h00);
        chk("R1 pad_out reset", pad_out, 8'h00);
        // R10: unused select reads zero, select changes show same cycle
        read_view(2'd3, v); chk("R10 zero view", v, 8'h00);
        read_view(2'd0, v); chk("R10 same-cycle select", v, IMPL);

        // R2 / R8: direction sweep
        for (int i = 0; i < 256; i++) begin
            write_reg(0, 8'(i));
            read_view(2'd0, v);
            chk("R2 dir readback", v, 8'(i) & IMPL);
            chk("R2 pad_oe from dir", pad_oe, ~8'(i) & IMPL);
        end

        // R3 / R4 / R7 / R8: latch sweep, alternating strobes, pins at complement
        write_reg(0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            pad_in = ~8'(i);
            write_reg((i % 2) ? 2 : 1, 8'(i));
            step();
            read_view(2'd1, v);
            chk((i % 2) ? "R4 port write to latch" : "R3 latch readback", v, 8'(i) & IMPL);
            chk("R7 pad_out from latch", pad_out, 8'(i) & IMPL);
            chk("R8 absent pad_oe", pad_oe & ~IMPL, 8'h00);
        end

        // R5 / R8: pin view through two flops
        rd_sel = 2'd2;
        pad_in = 8'h00;
        step(); step();
        prev = 8'h00;
        for (int i = 0; i < 256; i++) begin
            pad_in = 8'(i);
            step();
            #1 chk("R5 one edge holds old pins", rdata, prev & IMPL);
            step();
            #1 chk("R5 two edges show pins", rdata, 8'(i) & IMPL);
            prev = 8'(i);
        end

        // R6 / R7 / R9: override sweep
        dir_c = 8'hA5;
        lat_c = 8'h3C;
        write_reg(0, dir_c);
        write_reg(1, lat_c);
        pad_in = 8'h5B;
        step(); step();
        for (int i = 0; i < 256; i++) begin
            po = 8'(i * 3) ^ 8'h5A;
            pv = 8'(i) ^ 8'hC3;
            per_drive = 8'(i);
            per_oe = po;
            per_out = pv;
            own = 8'(i) & OVR & IMPL;
            read_view(2'd2, v);
            chk("R6 pad_oe ownership", pad_oe, ((own & po) | (~own & ~dir_c)) & IMPL);
            chk("R6 pad_out ownership", pad_out, ((own & pv) | (~own & lat_c)) & IMPL);
            chk("R9 input-only bits unaffected", pad_out & ~OVR & IMPL, lat_c & ~OVR & IMPL);
            chk("R6 pins still readable", v, 8'h5B & IMPL);
            step();
        end
        per_drive = '0;
        #1 chk("R7 port regains pads", pad_out, lat_c & IMPL);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule